// File: doc/BRIEF.md
# Interrupt-Paced Parallel Bus Mailbox

This block is the slave side of an asynchronous, non-multiplexed 16-bit memory-style bus driven by a host processor. It holds two mailbox regions that share one word address range. Host reads always return words from the outgoing region, which local logic fills. Host writes always land in the incoming region, which local logic consumes. The host's read and write strobes are active low and are only sampled by the fast internal clock; they never clock any flop. That clock must run at least four times the host bus access rate. If the board has a chip-select, it is ORed into each strobe before it reaches this block.

A fixed-period scheduler drives the exchange and never handshakes with the host. Each cycle is `CYCLE_TICKS` clocks long and has three named states. In ST_PUBLISH (one tick), the staged outgoing words are copied into the host-visible outgoing region. The transition PUBLISH_TO_HOST then opens ST_HOST. That state starts an active-low interrupt pulse and gives the host the rest of the first `WINDOW_TICKS` ticks to read the fresh data and write its results. The transition HOST_TO_CONSUME enters ST_CONSUME. On its first tick, the incoming region is snapshotted for local logic. On its last tick, a one-clock valid strobe is raised, and the transition CONSUME_TO_PUBLISH starts the next cycle. A host write that completes outside ST_HOST is dropped and counted.

The nominal figures are a 120 MHz clock, a 120 µs cycle with a 60 µs host half, and host accesses built from lead, active and trail phases of about 3, 5 and 2 host clocks.

Top module: `pbus_mailbox`

## Requirements
- R1: While `rst_n` is low, `host_irq_n` is 1, `in_valid` is 0 and `ovr_count` is 0. Every word of all four regions is 0, so host reads in the first cycle and `loc_rd_data` read before the first snapshot both return 0.
- R2: Let k be the number of rising clock edges since reset was released. After those edges the scheduler is in ST_PUBLISH when k mod CYCLE_TICKS is 0, in ST_HOST when it is from 1 to WINDOW_TICKS-1, and in ST_CONSUME otherwise.
- R3: `host_irq_n` is 0 exactly when k mod CYCLE_TICKS is from 1 to IRQ_TICKS, and 1 at all other times.
- R4: While `bus_rd_n` has been low for at least two clocks, `bus_data` carries the outgoing-region word selected by `bus_addr`. Host reads never return incoming-region contents, even at an address the host has just written. The bus is released two clocks after `bus_rd_n` rises.
- R5: The outgoing region loads the whole staging region only on the clock edge taken in ST_PUBLISH. A local write (`loc_wr_en`) only changes staging, so the host sees it in the first cycle that publishes after the write.
- R6: A host write commits on the detected rising edge of `bus_wr_n`, within three clocks of that edge. The word goes into the incoming region at the `bus_addr`/`bus_data` values present while `bus_wr_n` was low, provided the scheduler is in ST_HOST on the committing edge.
- R7: A host write that commits while the scheduler is not in ST_HOST leaves the incoming region unchanged and increments `ovr_count`. The counter saturates at 2^CNT_W-1 and never decreases except through reset.
- R8: On the clock edge where k mod CYCLE_TICKS equals WINDOW_TICKS, the whole incoming region is copied into a snapshot. `loc_rd_data` returns the snapshot word at `loc_rd_addr`. `in_valid` is a one-clock pulse, high exactly when k mod CYCLE_TICKS is CYCLE_TICKS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal clock (at least 4x the host access rate) |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Low host address bits; select a mailbox word |
| bus_data | inout | DW | Host data bus; driven by the block only during reads |
| bus_rd_n | input | 1 | Host read strobe, active low (chip-select already ORed in) |
| bus_wr_n | input | 1 | Host write strobe, active low (chip-select already ORed in) |
| host_irq_n | output | 1 | Active-low interrupt pulse marking fresh outgoing data |
| loc_wr_en | input | 1 | Local write into the outgoing staging region |
| loc_wr_addr | input | AW | Staging word address |
| loc_wr_data | input | DW | Staging word data |
| loc_rd_addr | input | AW | Snapshot word address |
| loc_rd_data | output | DW | Snapshot word at `loc_rd_addr` |
| in_valid | output | 1 | One-clock strobe at the end of the consume phase |
| ovr_count | output | CNT_W | Saturating count of host writes outside the window |

## Verification
A wrong scheduler state or counter shows up within one clock as a misplaced `host_irq_n` edge or `in_valid` pulse. The bench compares both against its own tick count on every clock. A wrong publish or snapshot instant stays hidden until the next host read or local snapshot read. The bench places those reads after each boundary, so such an error shows up in the following half cycle. A wrong window decision on a host write shows up as a changed `ovr_count` or as a snapshot word that differs from the bench's expected word, both checked in the consume half that follows.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    typedef enum logic [1:0] {
        ST_PUBLISH = 2'd0,
        ST_HOST    = 2'd1,
        ST_CONSUME = 2'd2
    } mbx_state_e;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/mbx_wr_port.sv
module mbx_wr_port #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic          commit,
    output logic [AW-1:0] commit_addr,
    output logic [DW-1:0] commit_data
);
    logic wr_lvl;
    logic wr_lvl_d;

    mbx_sync #(.W(1), .RST_VAL(1'b1)) u_wr_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (wr_n),
        .q     (wr_lvl)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_lvl_d    <= 1'b1;
            commit_addr <= '0;
            commit_data <= '0;
        end else begin
            wr_lvl_d <= wr_lvl;
            // Hold the last address/data seen while the strobe was low.
            if (!wr_n) begin
                commit_addr <= addr;
                commit_data <= din;
            end
        end
    end

    assign commit = wr_lvl & ~wr_lvl_d;
endmodule

// File: rtl/mbx_sched.sv
module mbx_sched
    import mbx_pkg::*;
#(
    parameter int CYCLE_TICKS  = 14400,
    parameter int WINDOW_TICKS = 7200,
    parameter int IRQ_TICKS    = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    output mbx_state_e state,
    output logic       publish,
    output logic       win_open,
    output logic       snap,
    output logic       in_valid,
    output logic       irq_n
);
    localparam int CW = $clog2(CYCLE_TICKS);

    mbx_state_e    nxt;
    logic [CW-1:0] cnt;
    logic          cyc_end;

    assign cyc_end = (cnt == CW'(CYCLE_TICKS - 1));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_PUBLISH: nxt = ST_HOST;
            ST_HOST:    if (cnt == CW'(WINDOW_TICKS - 1)) nxt = ST_CONSUME;
            ST_CONSUME: if (cyc_end) nxt = ST_PUBLISH;
            default:    nxt = ST_PUBLISH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_PUBLISH;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cyc_end ? '0 : cnt + CW'(1);
        end
    end

    always_comb begin
        publish  = (state == ST_PUBLISH);
        win_open = (state == ST_HOST);
        snap     = (state == ST_CONSUME) && (cnt == CW'(WINDOW_TICKS));
        in_valid = (state == ST_CONSUME) && cyc_end;
        irq_n    = !((state == ST_HOST) && (cnt <= CW'(IRQ_TICKS)));
    end
endmodule

// File: rtl/pbus_mailbox.sv
module pbus_mailbox
    import mbx_pkg::*;
#(
    parameter int AW           = 6,
    parameter int DW           = 16,
    parameter int CYCLE_TICKS  = 14400,
    parameter int WINDOW_TICKS = 7200,
    parameter int IRQ_TICKS    = 24,
    parameter int CNT_W        = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    inout  wire  [DW-1:0]    bus_data,
    input  logic             bus_rd_n,
    input  logic             bus_wr_n,
    output logic             host_irq_n,
    input  logic             loc_wr_en,
    input  logic [AW-1:0]    loc_wr_addr,
    input  logic [DW-1:0]    loc_wr_data,
    input  logic [AW-1:0]    loc_rd_addr,
    output logic [DW-1:0]    loc_rd_data,
    output logic             in_valid,
    output logic [CNT_W-1:0] ovr_count
);
    localparam int WORDS = 1 << AW;

    logic [WORDS-1:0][DW-1:0] stage_q;
    logic [WORDS-1:0][DW-1:0] out_q;
    logic [WORDS-1:0][DW-1:0] in_q;
    logic [WORDS-1:0][DW-1:0] snap_q;

    mbx_state_e    sched_state;
    logic          publish, win_open, snap;
    logic          rd_lvl;
    logic          wr_commit;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    mbx_sched #(
        .CYCLE_TICKS  (CYCLE_TICKS),
        .WINDOW_TICKS (WINDOW_TICKS),
        .IRQ_TICKS    (IRQ_TICKS)
    ) u_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (sched_state),
        .publish  (publish),
        .win_open (win_open),
        .snap     (snap),
        .in_valid (in_valid),
        .irq_n    (host_irq_n)
    );

    mbx_sync #(.W(1), .RST_VAL(1'b1)) u_rd_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_rd_n),
        .q     (rd_lvl)
    );

    mbx_wr_port #(.AW(AW), .DW(DW)) u_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_n        (bus_wr_n),
        .addr        (bus_addr),
        .din         (bus_data),
        .commit      (wr_commit),
        .commit_addr (wr_addr),
        .commit_data (wr_data)
    );

    // Outgoing side: local staging, copied wholesale at publish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            out_q   <= '0;
        end else begin
            if (publish) out_q <= stage_q;
            if (loc_wr_en) stage_q[loc_wr_addr] <= loc_wr_data;
        end
    end

    // Incoming side: host writes gated by the window, snapshot for local use.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q      <= '0;
            snap_q    <= '0;
            ovr_count <= '0;
        end else begin
            if (wr_commit) begin
                if (win_open)
                    in_q[wr_addr] <= wr_data;
                else if (ovr_count != '1)
                    ovr_count <= ovr_count + CNT_W'(1);
            end
            if (snap) snap_q <= in_q;
        end
    end

    assign bus_data    = rd_lvl ? 'z : out_q[bus_addr];
    assign loc_rd_data = snap_q[loc_rd_addr];
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
    import mbx_pkg::*;
#(
    parameter int AW    = 6,
    parameter int DW    = 16,
    parameter int CNT_W = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input mbx_state_e                    st,
    input logic                          irq_n,
    input logic                          in_valid,
    input logic [CNT_W-1:0]              ovr,
    input logic [(1<<AW)-1:0][DW-1:0]    out_q,
    input logic [(1<<AW)-1:0][DW-1:0]    snap_q
);
    // R3: the interrupt only starts right after a publish tick
    assert_irq_after_publish_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(st) == ST_PUBLISH);

    // R8: valid is a single-clock pulse followed by the next publish
    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!in_valid && st == ST_PUBLISH));

    // R5: the host-visible region only changes on a publish edge
    assert_out_publish_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_q) |-> $past(st) == ST_PUBLISH);

    // R7: overrun counter never decreases
    assert_ovr_monotonic_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovr >= $past(ovr));

    // R7: overrun counter only moves outside the host window
    assert_ovr_outside_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovr != $past(ovr) |-> $past(st) != ST_HOST);

    // R8: snapshot only changes while consuming
    assert_snap_in_consume_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(snap_q) |-> $past(st) == ST_CONSUME);
endmodule

bind pbus_mailbox mbx_checker #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (sched_state),
    .irq_n    (host_irq_n),
    .in_valid (in_valid),
    .ovr      (ovr_count),
    .out_q    (out_q),
    .snap_q   (snap_q)
);

// File: tb/pbus_mailbox_test.sv
module pbus_mailbox_test;
    localparam int AW    = 3;
    localparam int DW    = 16;
    localparam int C     = 600;
    localparam int W     = 300;
    localparam int IRQ   = 4;
    localparam int CNT_W = 2;
    localparam int WORDS = 1 << AW;
    localparam int OVR_MAX = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst_n;
    logic [AW-1:0]    bus_addr;
    wire  [DW-1:0]    bus_data;
    logic [DW-1:0]    host_d;
    logic             host_oe;
    logic             bus_rd_n, bus_wr_n;
    logic             host_irq_n;
    logic             loc_wr_en;
    logic [AW-1:0]    loc_wr_addr, loc_rd_addr;
    logic [DW-1:0]    loc_wr_data, loc_rd_data;
    logic             in_valid;
    logic [CNT_W-1:0] ovr_count;

    assign bus_data = host_oe ? host_d : 'z;

    pbus_mailbox #(
        .AW(AW), .DW(DW), .CYCLE_TICKS(C), .WINDOW_TICKS(W),
        .IRQ_TICKS(IRQ), .CNT_W(CNT_W)
    ) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .host_irq_n(host_irq_n),
        .loc_wr_en(loc_wr_en), .loc_wr_addr(loc_wr_addr), .loc_wr_data(loc_wr_data),
        .loc_rd_addr(loc_rd_addr), .loc_rd_data(loc_rd_data),
        .in_valid(in_valid), .ovr_count(ovr_count)
    );

    // Behavioural reference model
    int          k = 0;
    logic [DW-1:0] stage_e [WORDS];
    logic [DW-1:0] out_e   [WORDS];
    logic [DW-1:0] in_e    [WORDS];
    logic [DW-1:0] snap_e  [WORDS];
    int          ovr_e = 0;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    initial begin
        for (int i = 0; i < WORDS; i++) begin
            stage_e[i] = '0; out_e[i] = '0; in_e[i] = '0; snap_e[i] = '0;
        end
    end

    always @(posedge clk) begin
        if (rst_n) begin
            if (k % C == 0) out_e = stage_e;
            if (k % C == W) snap_e = in_e;
            if (loc_wr_en) stage_e[loc_wr_addr] = loc_wr_data;
            k++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison of the scheduler outputs
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 R3 host_irq_n", 32'(host_irq_n),
                32'(!((k % C) >= 1 && (k % C) <= IRQ)));
            chk("R8 in_valid", 32'(in_valid), 32'(k > 0 && (k % C) == C - 1));
        end
    end

    task automatic wait_tick(input int n);
        forever begin
            @(negedge clk);
            if (k % C == n) break;
        end
    endtask

    task automatic loc_write(input int a, input int d);
        @(negedge clk);
        loc_wr_en   = 1'b1;
        loc_wr_addr = AW'(a);
        loc_wr_data = DW'(d);
        @(negedge clk);
        loc_wr_en = 1'b0;
    endtask

    task automatic host_read(input int a, input string tag);
        @(negedge clk);
        bus_addr = AW'(a);
        repeat (6) @(negedge clk);
        bus_rd_n = 1'b0;
        repeat (10) @(negedge clk);
        chk(tag, 32'(bus_data), 32'(out_e[a]));
        bus_rd_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic host_write(input int a, input int d);
        int ph;
        @(negedge clk);
        bus_addr = AW'(a);
        host_d   = DW'(d);
        host_oe  = 1'b1;
        repeat (6) @(negedge clk);
        bus_wr_n = 1'b0;
        repeat (10) @(negedge clk);
        bus_wr_n = 1'b1;
        ph = k % C;
        if (ph >= 1 && ph + 4 < W) in_e[a] = DW'(d);
        else if (ovr_e < OVR_MAX) ovr_e++;
        repeat (4) @(negedge clk);
        host_oe = 1'b0;
    endtask

    task automatic check_snapshot(input string tag);
        for (int i = 0; i < WORDS; i++) begin
            @(negedge clk);
            loc_rd_addr = AW'(i);
            @(negedge clk);
            chk(tag, 32'(loc_rd_data), 32'(snap_e[i]));
        end
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        rst_n = 1'b0; bus_rd_n = 1'b1; bus_wr_n = 1'b1; host_oe = 1'b0;
        host_d = '0; bus_addr = '0; loc_wr_en = 1'b0; loc_wr_addr = '0;
        loc_wr_data = '0; loc_rd_addr = '0;
        repeat (5) @(negedge clk);
        // R1: reset state
        chk("R1 irq_n in reset", 32'(host_irq_n), 32'd1);
        chk("R1 in_valid in reset", 32'(in_valid), 32'd0);
        chk("R1 ovr_count in reset", 32'(ovr_count), 32'd0);
        chk("R1 snapshot in reset", 32'(loc_rd_data), 32'd0);
        rst_n = 1'b1;

        // Cycle 0: host window
        wait_tick(2);
        for (int i = 0; i < 4; i++) host_read(i, "R1 R4 first-cycle read is zero");
        for (int i = 0; i < WORDS; i++) loc_write(i, 32'hA000 + i);
        host_read(5, "R5 staging not visible before publish");
        for (int i = 0; i < 4; i++) host_write(i, 32'h1100 + i);

        // Cycle 0: consume phase, overrun write
        wait_tick(310);
        host_write(0, 32'hFFFF);
        chk("R7 overrun counted", 32'(ovr_count), 32'(ovr_e));
        check_snapshot("R6 R7 R8 snapshot after first window");

        // Cycle 1: published staging, separate regions
        wait_tick(2);
        for (int i = 0; i < WORDS; i++) host_read(i, "R4 R5 published word");
        host_write(7, 32'h7777);
        host_read(7, "R4 read ignores incoming region");

        // Cycle 1: overruns up to saturation
        wait_tick(320);
        for (int i = 0; i < 3; i++) host_write(i + 1, 32'hBEE0 + i);
        chk("R7 overrun saturates", 32'(ovr_count), 32'(OVR_MAX));

        // Cycle 2: snapshot holds host data, overruns absent
        wait_tick(305);
        check_snapshot("R6 R7 R8 snapshot after second window");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule